// File: doc/BRIEF.md
# Clock Fan-out Output Enable Controller

This block decides, for every channel of a 20-way clock fan-out, whether that output carries the reference clock, sits at a driven low, or is released to high impedance. Each channel produces two signals. The first is a gated copy of the reference clock. The second is a drive-enable that tells the output stage whether to drive the pin or float it.

The decision is made in layers. The board power state comes first. When power-good is low, every output is driven low. When power-good is high and the active-low power-down input is low, every output floats. Only when both inputs are high do the per-channel controls take effect.

A mode pin selects how the channels are controlled:
- Register mode: each channel follows its enable bit. Channels 5 to 12 also need their active-low hardware pin to be low. Those pins are asynchronous and pass through a two-flop synchroniser first.
- Serial mode: each channel follows its bit in a shift-register image, unless its mask bit is set. A set mask bit forces the channel on.

The per-channel enable is captured on the falling edge of the reference clock. The gate therefore never opens or closes during a high phase.

Top module: `clkbuf_oe_ctrl`

## Requirements
- R1: While pwr_good_i is 0, every bit of clk_o is 0 and every bit of drive_en_o is 1, with no clock edge needed.
- R2: While pwr_good_i is 1 and pwr_dn_ni is 0, every bit of drive_en_o is 0 and every bit of clk_o is 0.
- R3: In register mode (serial_mode_i = 0), channels 0 to 4 and 13 to 19 run exactly when their reg_en_i bit is 1.
- R4: In register mode, channel c in 5 to 12 runs only when reg_en_i[c] is 1 and hw_oe_ni[c-5] is 0 after synchronisation.
- R5: A hw_oe_ni change is sampled by two rising-edge flops. It therefore reaches the gate at the first falling edge after the second rising edge that samples it.
- R6: In serial mode (serial_mode_i = 1), channel c runs exactly when mask_i[c] or shift_en_i[c] is 1. In this mode reg_en_i and hw_oe_ni have no effect.
- R7: The gate of each channel changes only at a falling edge of clk_i, so clk_o is 0 whenever clk_i is low.
- R8: With pwr_good_i and pwr_dn_ni both 1, a disabled channel has clk_o 0 and drive_en_o 1.
- R9: After rst_ni is asserted, all gates are closed and the synchronised pins read as deasserted (1) until new values are captured.
- R10: An enable decision present at a falling edge of clk_i gates clk_o from the next rising edge for the whole high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Power good; 0 drives all outputs low |
| pwr_dn_ni | input | 1 | Active-low power-down; 0 floats all outputs |
| serial_mode_i | input | 1 | 1 selects serial shift/mask control, 0 selects register control |
| reg_en_i | input | 20 | Per-channel register enable bits |
| hw_oe_ni | input | 8 | Active-low asynchronous enables for channels 5..12 (bit 0 is channel 5) |
| shift_en_i | input | 20 | Serial shift-register enable image |
| mask_i | input | 20 | Per-channel mask; 1 forces the channel on in serial mode |
| clk_o | output | 20 | Gated clock per channel |
| drive_en_o | output | 20 | 1 drives the pin, 0 floats it |

## Verification
Assertions check four things at every clock edge:
- both power overrides, at the ports;
- that a cleared register bit in register mode, or a set mask bit in serial mode, closes or opens the captured gate at the next falling edge;
- the two-cycle latency of the pin synchroniser.

The bench runs a behavioural model of the pin pipeline and the falling-edge capture. It compares every channel in both clock phases on every cycle. This is the only way to show that clk_o never goes high in a low phase. The bench scenarios also cover:
- the reset state;
- the pin latency seen at the output;
- the fact that pins and register bits are ignored in serial mode;
- the return from power-down to running clocks.

// File: rtl/clkbuf_pkg.sv
`timescale 1ns/1ps
package clkbuf_pkg;
  parameter int unsigned NUM_CH  = 20;
  parameter int unsigned PIN_LO  = 5;
  parameter int unsigned NUM_PIN = 8;
  localparam int unsigned PIN_HI = PIN_LO + NUM_PIN - 1;
endpackage

// File: rtl/clkbuf_pin_sync.sv
`timescale 1ns/1ps
module clkbuf_pin_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] meta_q, sync_q;
  logic [1:0]   age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
      age_q  <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  assign pin_o = sync_q;

  assert_sync_lat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (pin_o == $past(pin_i, 2)));
endmodule

// File: rtl/clkbuf_en_select.sv
`timescale 1ns/1ps
module clkbuf_en_select
  import clkbuf_pkg::*;
#(
  parameter int unsigned N  = NUM_CH,
  parameter int unsigned LO = PIN_LO,
  parameter int unsigned NP = NUM_PIN
) (
  input  logic          serial_mode_i,
  input  logic [N-1:0]  reg_en_i,
  input  logic [NP-1:0] pin_n_i,
  input  logic [N-1:0]  shift_en_i,
  input  logic [N-1:0]  mask_i,
  output logic [N-1:0]  want_o
);
  for (genvar c = 0; c < N; c++) begin : g_ch
    logic reg_ok;
    if (c >= LO && c < LO + NP) begin : g_pin
      assign reg_ok = reg_en_i[c] & ~pin_n_i[c-LO];
    end else begin : g_nopin
      assign reg_ok = reg_en_i[c];
    end
    assign want_o[c] = serial_mode_i ? (mask_i[c] | shift_en_i[c]) : reg_ok;
  end
endmodule

// File: rtl/clkbuf_gate.sv
`timescale 1ns/1ps
module clkbuf_gate #(
  parameter int unsigned N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] want_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] clk_gate_o
);
  logic [N-1:0] en_q;

  // capture while clock is low: gate edges never cut a high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= want_i;
  end

  for (genvar c = 0; c < N; c++) begin : g_and
    assign clk_gate_o[c] = clk_i & en_q[c];
  end

  assign en_o = en_q;
endmodule

// File: rtl/clkbuf_oe_ctrl.sv
`timescale 1ns/1ps
module clkbuf_oe_ctrl
  import clkbuf_pkg::*;
#(
  parameter int unsigned N  = NUM_CH,
  parameter int unsigned LO = PIN_LO,
  parameter int unsigned NP = NUM_PIN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_good_i,
  input  logic          pwr_dn_ni,
  input  logic          serial_mode_i,
  input  logic [N-1:0]  reg_en_i,
  input  logic [NP-1:0] hw_oe_ni,
  input  logic [N-1:0]  shift_en_i,
  input  logic [N-1:0]  mask_i,
  output logic [N-1:0]  clk_o,
  output logic [N-1:0]  drive_en_o
);
  logic [NP-1:0] pin_sync;
  logic [N-1:0]  want;
  logic [N-1:0]  gate_en;
  logic [N-1:0]  gated;
  logic          run_ok;

  clkbuf_pin_sync #(.W(NP)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (hw_oe_ni),
    .pin_o (pin_sync)
  );

  clkbuf_en_select #(.N(N), .LO(LO), .NP(NP)) u_sel (
    .serial_mode_i(serial_mode_i),
    .reg_en_i     (reg_en_i),
    .pin_n_i      (pin_sync),
    .shift_en_i   (shift_en_i),
    .mask_i       (mask_i),
    .want_o       (want)
  );

  clkbuf_gate #(.N(N)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .want_i    (want),
    .en_o      (gate_en),
    .clk_gate_o(gated)
  );

  // power overrides are combinational: reference clock may be absent
  assign run_ok     = pwr_good_i & pwr_dn_ni;
  assign clk_o      = run_ok ? gated : '0;
  assign drive_en_o = (!pwr_good_i || pwr_dn_ni) ? '1 : '0;

  assert_pg_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> (clk_o == '0 && drive_en_o == '1));

  assert_pd_float_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && !pwr_dn_ni) |-> (drive_en_o == '0 && clk_o == '0));

  for (genvar c = 0; c < N; c++) begin : g_chk
    assert_reg_off_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!serial_mode_i && !reg_en_i[c]) |=> !gate_en[c]);
    assert_mask_force_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (serial_mode_i && mask_i[c]) |=> gate_en[c]);
  end
endmodule

// File: tb/clkbuf_oe_ctrl_tb.sv
`timescale 1ns/1ps
module clkbuf_oe_ctrl_tb;
  localparam int N = 20;
  localparam int NP = 8;
  localparam int LO = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b1, pd_n = 1'b1, smode = 1'b0;
  logic [N-1:0] reg_en = '0, shift_en = '0, mask = '0;
  logic [NP-1:0] hw_n = '1;
  logic [N-1:0] clk_o, drv_o;

  int checks = 0, fails = 0;
  string cur_req = "R9";

  always #2 clk = ~clk;

  clkbuf_oe_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .pwr_dn_ni(pd_n),
    .serial_mode_i(smode), .reg_en_i(reg_en), .hw_oe_ni(hw_n),
    .shift_en_i(shift_en), .mask_i(mask), .clk_o(clk_o), .drive_en_o(drv_o)
  );

  // behavioural reference: pin history queue and captured enables
  logic [NP-1:0] pin_hist[$];
  logic [N-1:0]  en_model;

  function automatic logic [N-1:0] model_want();
    logic [N-1:0] w;
    for (int c = 0; c < N; c++) begin
      if (smode) w[c] = mask[c] | shift_en[c];
      else if (c >= LO && c < LO + NP) w[c] = reg_en[c] & ~pin_hist[0][c-LO];
      else w[c] = reg_en[c];
    end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hist = {'1, '1};
    end else begin
      pin_hist.push_back(hw_n);
      void'(pin_hist.pop_front());
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_model = '0;
    else en_model = model_want();
  end

  task automatic cmp(string req, logic [N-1:0] act, logic [N-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] exp_drv();
    return (!pg || pd_n) ? '1 : '0;
  endfunction

  // high phase and low phase comparison every cycle
  always @(posedge clk) begin
    #0.5;
    if (rst_n) begin
      cmp(cur_req, clk_o, (pg && pd_n) ? en_model : '0, "clk_o high phase");
      cmp(cur_req, drv_o, exp_drv(), "drive_en_o");
    end
  end
  always @(negedge clk) begin
    #1.5;
    if (rst_n) cmp("R7", clk_o, '0, "clk_o low phase");
  end

  task automatic set_in(input logic g, input logic d, input logic s,
                        input logic [N-1:0] r, input logic [NP-1:0] h,
                        input logic [N-1:0] sh, input logic [N-1:0] m);
    @(negedge clk); #0.5;
    pg = g; pd_n = d; smode = s; reg_en = r; hw_n = h; shift_en = sh; mask = m;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    // R9: reset state
    #3;
    cmp("R9", clk_o, '0, "clk_o in reset");
    cmp("R9", drv_o, '1, "drive_en_o in reset");
    #4 rst_n = 1'b1;
    run(3);

    // R3: pinless channels follow register bits, pins deasserted
    cur_req = "R3";
    set_in(1, 1, 0, 20'hFFFFF, 8'hFF, '0, '0); run(5);
    set_in(1, 1, 0, 20'hA5C3E, 8'hFF, '0, '0); run(5);

    // R4: pinned channels need pin low
    cur_req = "R4";
    set_in(1, 1, 0, 20'hFFFFF, 8'h00, '0, '0); run(5);
    set_in(1, 1, 0, 20'h0F0F0, 8'hA5, '0, '0); run(5);

    // R5: pin latency, one pin toggling every cycle then held
    cur_req = "R5";
    for (int i = 0; i < 6; i++) begin
      set_in(1, 1, 0, 20'hFFFFF, (i % 2) ? 8'h01 : 8'h80, '0, '0);
    end
    run(4);

    // R6: serial mode ignores registers and pins
    cur_req = "R6";
    set_in(1, 1, 1, 20'h00000, 8'h00, 20'h0000F, 20'hF0000); run(5);
    set_in(1, 1, 1, 20'hFFFFF, 8'hFF, 20'h00000, 20'h01010); run(5);
    set_in(1, 1, 1, 20'h12345, 8'h3C, 20'hC3A50, 20'h00000); run(5);

    // R8: disabled channels drive low
    cur_req = "R8";
    set_in(1, 1, 0, 20'h00000, 8'h00, '0, '0); run(4);

    // R1: power-good low overrides, mid-run
    cur_req = "R1";
    set_in(0, 1, 0, 20'hFFFFF, 8'h00, '0, '0); run(4);
    set_in(0, 0, 1, 20'hFFFFF, 8'h00, '1, '1); run(3);

    // R2: power-down floats everything
    cur_req = "R2";
    set_in(1, 0, 0, 20'hFFFFF, 8'h00, '0, '0); run(4);

    // R10: per-cycle changes of the enable decision
    cur_req = "R10";
    for (int i = 0; i < 8; i++) begin
      set_in(1, 1, i[0], 20'h1 << i, 8'h00, 20'h80000 >> i, 20'h0);
    end
    run(3);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule